// File: doc/BRIEF.md
# Edge-Aligned PWM Timer

This block is a timer with one shared counter and two compare channels that produce edge-aligned PWM waveforms. The counter runs up or down over a programmable period of LOAD + 1 clock cycles. It either runs freely or stops after a single period.

Each channel watches four events: the counter at zero, the counter at LOAD, a compare match while counting up, and a compare match while counting down. A two-bit action code is set for each event and says what that event does to the channel's generated level. Behind the generator sit four output controls: a software-forced level selected by a source bit, a polarity inverter, an idle level and an output enable.

All configuration goes through a single synchronous write port. The outputs are meant to drive pins directly.

Top module: `ea_pwm_timer`

## Requirements
- R1: While the counter enable is 0, or the channel's output enable is 0, the channel pin equals the channel's idle bit. The idle bit is never inverted.
- R2: With the count-mode field at 2 (up), the counter starts at 0 when enabled. It counts up to LOAD and then wraps to 0, so the period is LOAD + 1 cycles.
- R3: With the count-mode field at 0 (down), the counter starts at LOAD when enabled. It counts down to 0 and then reloads LOAD, so the period is LOAD + 1 cycles.
- R4: The action codes are 0 = keep, 1 = drive high, 2 = drive low and 3 = toggle. The generated level takes the new value one cycle after the counter holds the value that caused the event. With no event, the level holds.
- R5: When several events fire in the same cycle, the highest-priority event with a non-zero code decides the level. Compare has the highest priority, then load, then zero.
- R6: A compare value greater than LOAD never produces a compare event.
- R7: With the repeat bit at 0, the counter stops after one period and holds its final value. No further events fire until the counter is disabled and enabled again.
- R8: With the output-select bit at 1, the forced-level bit replaces the generated level. With the output-select bit at 0, the generated level is used.
- R9: With the invert bit at 1, the selected level (generated or forced) is inverted before it reaches the pin.
- R10: Disabling the counter clears every channel's generated level to low.
- R11: A write takes effect on the clock edge that samples it. The register map is:
  - Address 0 is control: bit 0 enable, bits 2:1 count mode, bit 3 repeat.
  - Address 1 is LOAD.
  - Addresses 2 and 3 are the compare values of channels 0 and 1.
  - Addresses 4 and 5 are the action registers of channels 0 and 1: bits 1:0 zero, bits 3:2 load, bits 5:4 compare-up, bits 7:6 compare-down.
  - Addresses 6 and 7 are the output registers of channels 0 and 1: bit 0 source select, bit 1 forced level, bit 2 invert, bit 3 idle level, bit 4 output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | NCH | Channel pins |

## Verification
The assertions on counter stepping assume that the count mode and LOAD change only while the counter is disabled. Between two samples they allow only one of two things: a step of one, or the disable itself. The bench writes every counter setting while the enable is 0 and changes only the output registers while the counter runs. The checks on the generated level assume that events come only from a counter that is running; the bench never sets a compare value so far above LOAD that it could wrap the counter width.

// File: rtl/ea_pwm_pkg.sv
package ea_pwm_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_HIGH   = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    // field order follows the action register bit layout (MSB first)
    typedef struct packed {
        act_e on_dn;
        act_e on_up;
        act_e on_load;
        act_e on_zero;
    } act_cfg_t;

    typedef struct packed {
        logic oe;
        logic idle;
        logic inv;
        logic force_val;
        logic osel;
    } out_cfg_t;

    localparam int CTRL_ADDR = 0;
    localparam int LOAD_ADDR = 1;
    localparam int CMP_BASE  = 2;

endpackage

// File: rtl/ea_pwm_regs.sv
module ea_pwm_regs
    import ea_pwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    output logic                           en,
    output logic [1:0]                     mode,
    output logic                           rpt,
    output logic [CNT_W-1:0]               load,
    output logic [NCH-1:0][CNT_W-1:0]      cmp,
    output act_cfg_t [NCH-1:0]             act,
    output out_cfg_t [NCH-1:0]             ocfg
);
    localparam int ACT_BASE = CMP_BASE + NCH;
    localparam int OUT_BASE = ACT_BASE + NCH;

    typedef struct packed {
        logic                      en;
        logic [1:0]                mode;
        logic                      rpt;
        logic [CNT_W-1:0]          load;
        logic [NCH-1:0][CNT_W-1:0] cmp;
        act_cfg_t [NCH-1:0]        act;
        out_cfg_t [NCH-1:0]        ocfg;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                d.en   = wr_data[0];
                d.mode = wr_data[2:1];
                d.rpt  = wr_data[3];
            end
            if (wr_addr == ADDR_W'(LOAD_ADDR)) begin
                d.load = wr_data;
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(CMP_BASE + i)) d.cmp[i]  = wr_data;
                if (wr_addr == ADDR_W'(ACT_BASE + i)) d.act[i]  = act_cfg_t'(wr_data[7:0]);
                if (wr_addr == ADDR_W'(OUT_BASE + i)) d.ocfg[i] = out_cfg_t'(wr_data[4:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en   = q.en;
    assign mode = q.mode;
    assign rpt  = q.rpt;
    assign load = q.load;
    assign cmp  = q.cmp;
    assign act  = q.act;
    assign ocfg = q.ocfg;

endmodule

// File: rtl/ea_pwm_counter.sv
module ea_pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up,
    input  logic             rpt,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             zero_ev,
    output logic             load_ev
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t q, d;
    logic [CNT_W-1:0] start_d;

    always_comb begin
        d       = q;
        start_d = up ? '0 : load;
        active  = en && !q.done;
        if (!en) begin
            d.cnt  = start_d;
            d.done = 1'b0;
        end else if (active) begin
            if (up) begin
                if (q.cnt >= load) begin
                    if (rpt) d.cnt  = '0;
                    else     d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end else begin
                if (q.cnt == '0) begin
                    if (rpt) d.cnt  = load;
                    else     d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
        end
        zero_ev = active && (q.cnt == '0);
        load_ev = active && (q.cnt == load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && up && q.cnt < load) |=> (!en || q.cnt == $past(q.cnt) + CNT_W'(1)));

    // R3
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !up && q.cnt != '0) |=> (!en || q.cnt == $past(q.cnt) - CNT_W'(1)));

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.done) |=> (!en || $stable(q.cnt)));

endmodule

// File: rtl/ea_pwm_chan.sv
module ea_pwm_chan
    import ea_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             active,
    input  logic             up,
    input  logic [CNT_W-1:0] cnt,
    input  logic             zero_ev,
    input  logic             load_ev,
    input  logic [CNT_W-1:0] cmp,
    input  act_cfg_t         act,
    input  out_cfg_t         ocfg,
    output logic             pin
);
    typedef struct packed {
        logic gen;
    } chan_state_t;

    chan_state_t q, d;
    logic cmp_up_ev, cmp_dn_ev;
    act_e sel;

    always_comb begin
        cmp_up_ev = active && up  && (cnt == cmp);
        cmp_dn_ev = active && !up && (cnt == cmp);

        sel = ACT_KEEP;
        if (zero_ev   && act.on_zero != ACT_KEEP) sel = act.on_zero;
        if (load_ev   && act.on_load != ACT_KEEP) sel = act.on_load;
        if (cmp_up_ev && act.on_up   != ACT_KEEP) sel = act.on_up;
        if (cmp_dn_ev && act.on_dn   != ACT_KEEP) sel = act.on_dn;

        d = q;
        unique case (sel)
            ACT_HIGH:   d.gen = 1'b1;
            ACT_LOW:    d.gen = 1'b0;
            ACT_TOGGLE: d.gen = !q.gen;
            default:    d.gen = q.gen;
        endcase
        if (!en) d.gen = 1'b0;

        if (!en || !ocfg.oe) pin = ocfg.idle;
        else                 pin = (ocfg.osel ? ocfg.force_val : q.gen) ^ ocfg.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    hold_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !zero_ev && !load_ev && !cmp_up_ev && !cmp_dn_ev) |=> (q.gen == $past(q.gen)));

    // R5
    cmp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((cmp_up_ev && act.on_up == ACT_HIGH) || (cmp_dn_ev && act.on_dn == ACT_HIGH))) |=> q.gen);

    // R5
    cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((cmp_up_ev && act.on_up == ACT_LOW) || (cmp_dn_ev && act.on_dn == ACT_LOW))) |=> !q.gen);

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.gen);

endmodule

// File: rtl/ea_pwm_timer.sv
module ea_pwm_timer
    import ea_pwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_out
);
    logic                      en, rpt;
    logic [1:0]                mode;
    logic [CNT_W-1:0]          load, cnt;
    logic [NCH-1:0][CNT_W-1:0] cmp;
    act_cfg_t [NCH-1:0]        act;
    out_cfg_t [NCH-1:0]        ocfg;
    logic                      active, zero_ev, load_ev, up;

    ea_pwm_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en(en), .mode(mode), .rpt(rpt), .load(load), .cmp(cmp), .act(act), .ocfg(ocfg)
    );

    assign up = mode[1];

    ea_pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .up(up), .rpt(rpt), .load(load),
        .cnt(cnt), .active(active), .zero_ev(zero_ev), .load_ev(load_ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ea_pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en), .active(active), .up(up), .cnt(cnt),
            .zero_ev(zero_ev), .load_ev(load_ev), .cmp(cmp[g]), .act(act[g]),
            .ocfg(ocfg[g]), .pin(pwm_out[g])
        );
    end

    // R1
    idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (pwm_out == {ocfg[NCH-1].idle, ocfg[0].idle} || NCH != 2));

endmodule

// File: tb/ea_pwm_timer_bench.sv
`timescale 1ns/1ps
module ea_pwm_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ea_pwm_timer u_ea_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int v);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(v);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
        end
    endtask

    // level expected k cycles after enable, from the requirements
    function automatic bit exp_level(bit up, int k, int L, int C);
        int j;
        j = (k - 1) % (L + 1);
        if (C > L) return 1'b1;
        if (up) return j < C;
        return (L - j) > C;
    endfunction

    task automatic run_case(bit up, int L, int c0, int c1, int cyc);
        int ctl;
        string tag;
        ctl = (up ? 4 : 0) | 8;
        wr(0, ctl); wr(1, L); wr(2, c0); wr(3, c1);
        wr(4, up ? 'h21 : 'h84); wr(5, up ? 'h21 : 'h84);
        wr(6, 'h10); wr(7, 'h10);
        wr(0, ctl | 1);
        chk(pwm_out[0], 1'b0, "R10 cleared after disable");
        for (int k = 1; k <= cyc; k++) begin
            tick();
            tag = up ? "R2 up" : "R3 down";
            if (c0 > L) tag = {tag, " R6"};
            if (c0 == 0 || c0 == L) tag = {tag, " R5"};
            chk(pwm_out[0], exp_level(up, k, L, c0), {tag, " R4 ch0"});
            chk(pwm_out[1], exp_level(up, k, L, c1), {tag, " R4 ch1"});
        end
        wr(0, ctl);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(pwm_out[0], 1'b0, "R1 reset idle ch0");
        chk(pwm_out[1], 1'b0, "R1 reset idle ch1");
        wr(6, 'h08); wr(7, 'h1C);
        chk(pwm_out[0], 1'b1, "R1 idle with oe off");
        chk(pwm_out[1], 1'b1, "R1 R9 idle not inverted");

        // sweeps over period and compare values
        for (int L = 0; L <= 4; L++)
            for (int c = 0; c <= L + 1; c++) begin
                run_case(1'b1, L, c, (c + 1) % (L + 2), 3 * (L + 1) + 1);
                run_case(1'b0, L, c, (c + 1) % (L + 2), 3 * (L + 1) + 1);
            end

        // R4 toggle and keep codes: zero toggles, compare-up keeps
        wr(0, 12); wr(1, 3); wr(2, 1); wr(4, 'h03); wr(6, 'h10);
        wr(0, 13);
        for (int k = 1; k <= 16; k++) begin
            tick();
            chk(pwm_out[0], ((((k - 1) / 4) + 1) % 2) == 1, "R4 toggle");
        end
        wr(0, 12);

        // R7 one-shot up
        wr(0, 4); wr(1, 3); wr(2, 2); wr(4, 'h21); wr(6, 'h10);
        wr(0, 5);
        for (int k = 1; k <= 14; k++) begin
            tick();
            chk(pwm_out[0], (k <= 4) ? exp_level(1'b1, k, 3, 2) : 1'b0, "R7 one-shot up");
        end
        wr(0, 4);

        // R7 one-shot down
        wr(0, 0); wr(2, 1); wr(4, 'h84);
        wr(0, 1);
        for (int k = 1; k <= 14; k++) begin
            tick();
            chk(pwm_out[0], (k <= 4) ? exp_level(1'b0, k, 3, 1) : 1'b0, "R7 one-shot down");
        end
        wr(0, 0);

        // R9 inversion of generated level
        wr(0, 12); wr(1, 4); wr(2, 2); wr(4, 'h21); wr(6, 'h14);
        wr(0, 13);
        for (int k = 1; k <= 10; k++) begin
            tick();
            chk(pwm_out[0], !exp_level(1'b1, k, 4, 2), "R9 inverted");
        end

        // R8 forced level, R11 write timing
        wr(6, 'h13);
        chk(pwm_out[0], 1'b1, "R8 R11 forced high");
        for (int k = 0; k < 6; k++) begin
            tick();
            chk(pwm_out[0], 1'b1, "R8 forced high held");
        end
        wr(6, 'h11);
        chk(pwm_out[0], 1'b0, "R8 R11 forced low");
        wr(6, 'h17);
        chk(pwm_out[0], 1'b0, "R8 R9 forced high inverted");

        // R1 output enable off while running
        wr(6, 'h08);
        chk(pwm_out[0], 1'b1, "R1 oe off running idle 1");
        wr(6, 'h00);
        chk(pwm_out[0], 1'b0, "R1 oe off running idle 0");
        wr(0, 12);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule